// File: doc/BRIEF.md
# Fixed-point scaled timestamp counter

This block produces a 64-bit timestamp for neighbouring timer logic. It counts clock cycles, but not necessarily one unit per cycle. Internally it holds an 88-bit accumulator made of a 64-bit integer part and a 24-bit fraction. On each enabled cycle it adds an increment to this accumulator. When scaling is on, the increment is a programmable 32-bit value in which 0x0100_0000 stands for 1.0. When scaling is off, the increment is exactly one integer unit. The timestamp presented to consumers is the integer part of the accumulator.

Either 32-bit half of the timestamp can be loaded independently while the counter runs. The half that is not written keeps its live value. Any load clears the fraction. A load takes priority over the tick of the same cycle. The scale value sits in a register that resets to 1.0 and is loaded through its own strobe.

Top module: `stamp_counter`

## Requirements
- R1: After reset the count reads zero, the fraction is zero and the scale register holds 0x0100_0000 (1.0).
- R2: While the enable input is low and no load strobe is active, the count does not change.
- R3: With enable high and scale-enable low, the count rises by exactly one per cycle, and the fraction is left unchanged.
- R4: With enable high and scale-enable high, each cycle adds the scale register, taken as 8.24 fixed point, to the 88-bit accumulator. The count is accumulator bits 87..24.
- R5: A scale write, strobe high at a rising edge, loads the scale register at that edge. Ticks at that same edge still use the previous scale value.
- R6: A low-half load (lo_we_i) puts wdata_i into count bits 31..0. Bits 63..32 keep their present value and the fraction becomes zero.
- R7: A high-half load (hi_we_i) puts wdata_i into count bits 63..32. Bits 31..0 keep their present value and the fraction becomes zero.
- R8: If both load strobes are high in one cycle, both halves take wdata_i.
- R9: When a load and an enabled tick fall in the same cycle, the load wins and no increment is applied for that cycle.
- R10: The accumulator wraps modulo 2^88 with no flag. For example, all-ones count plus one unit gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; one potential tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable |
| scale_en_i | input | 1 | Select the scale register as increment (1) or one unit (0) |
| scale_we_i | input | 1 | Load strobe for the scale register |
| scale_wdata_i | input | 32 | New scale value, 8.24 fixed point |
| lo_we_i | input | 1 | Load strobe for count bits 31..0 |
| hi_we_i | input | 1 | Load strobe for count bits 63..32 |
| wdata_i | input | 32 | Data for either count half |
| count_o | output | 64 | Integer part of the accumulator |

## Verification
The bench targets the following corner cases:
- Fractional scales such as 0.5 and about 256. A design that carried the wrong number of fraction bits, or dropped the carry out of the fraction, would drift away from the reference within a few cycles.
- Loading a half while the fraction is non-zero. A design that failed to clear the fraction would then advance one cycle early.
- A load that coincides with a tick. A design that let the tick through would show the written value plus one.
- Loading all-ones followed by a tick. A design with a 64-bit overflow flag or a saturating adder would fail to wrap to zero.
- A scale write that coincides with a tick. A design that applied the new scale to that tick would step by the new value one cycle early.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  // kind of count load requested in a cycle
  typedef enum logic [1:0] {
    LOAD_NONE = 2'b00,
    LOAD_LO   = 2'b01,
    LOAD_HI   = 2'b10,
    LOAD_BOTH = 2'b11
  } load_kind_e;

  localparam int unsigned DEF_INT_W   = 64;
  localparam int unsigned DEF_FRAC_W  = 24;
  localparam int unsigned DEF_SCALE_W = 32;
endpackage

// File: rtl/stamp_scale_reg.sv
module stamp_scale_reg #(
  parameter int unsigned SCALE_W = 32,
  parameter int unsigned FRAC_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [SCALE_W-1:0] wdata_i,
  output logic [SCALE_W-1:0] scale_o
);
  localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << FRAC_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scale_o <= UNITY;
    else if (we_i) scale_o <= wdata_i;
  end

  // R5
  scale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> scale_o == $past(wdata_i));
  // R5
  scale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(scale_o));
endmodule

// File: rtl/stamp_accum.sv
module stamp_accum
  import stamp_pkg::*;
#(
  parameter int unsigned INT_W   = 64,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned SCALE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               scale_en_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic [INT_W/2-1:0] wdata_i,
  output logic [INT_W-1:0]   count_o,
  output logic [FRAC_W-1:0]  frac_o
);
  localparam int unsigned ACC_W  = INT_W + FRAC_W;
  localparam int unsigned HALF_W = INT_W / 2;

  typedef logic [ACC_W-1:0] acc_t;

  // increment for one tick: programmable scale or exactly one integer unit
  function automatic acc_t tick_inc(logic use_scale, logic [SCALE_W-1:0] sc);
    if (use_scale) return ACC_W'(sc);
    return acc_t'(1) << FRAC_W;
  endfunction

  // replace selected integer halves, zero the fraction
  function automatic acc_t deposit(acc_t cur, load_kind_e kind,
                                   logic [HALF_W-1:0] d);
    logic [INT_W-1:0] ip;
    ip = cur[ACC_W-1:FRAC_W];
    if (kind[0]) ip[HALF_W-1:0]     = d;
    if (kind[1]) ip[INT_W-1:HALF_W] = d;
    return {ip, {FRAC_W{1'b0}}};
  endfunction

  acc_t       acc_q;
  load_kind_e load_kind;
  logic       load_evt;   // some half is being written this cycle
  logic       tick_evt;   // an increment is applied this cycle

  assign load_kind = load_kind_e'({hi_we_i, lo_we_i});
  assign load_evt  = lo_we_i | hi_we_i;
  assign tick_evt  = en_i & ~load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (load_evt) acc_q <= deposit(acc_q, load_kind, wdata_i);
    else if (tick_evt) acc_q <= acc_q + tick_inc(scale_en_i, scale_i);
  end

  assign count_o = acc_q[ACC_W-1:FRAC_W];
  assign frac_o  = acc_q[FRAC_W-1:0];

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_evt) |=> ($stable(count_o) && $stable(frac_o)));
  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !scale_en_i && !load_evt) |=>
      (count_o == $past(count_o) + 1'b1 && frac_o == $past(frac_o)));
  // R6
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we_i && !hi_we_i) |=>
      (count_o[HALF_W-1:0] == $past(wdata_i) &&
       count_o[INT_W-1:HALF_W] == $past(count_o[INT_W-1:HALF_W]) &&
       frac_o == '0));
  // R7
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_i && !lo_we_i) |=>
      (count_o[INT_W-1:HALF_W] == $past(wdata_i) &&
       count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0]) &&
       frac_o == '0));
  // R8
  both_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_i && lo_we_i) |=> count_o == {2{$past(wdata_i)}});
  // R9
  load_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && en_i) |=> frac_o == '0);
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter
  import stamp_pkg::*;
#(
  parameter int unsigned INT_W   = DEF_INT_W,
  parameter int unsigned FRAC_W  = DEF_FRAC_W,
  parameter int unsigned SCALE_W = DEF_SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               scale_en_i,
  input  logic               scale_we_i,
  input  logic [SCALE_W-1:0] scale_wdata_i,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic [INT_W/2-1:0] wdata_i,
  output logic [INT_W-1:0]   count_o
);
  logic [SCALE_W-1:0] scale_q;
  logic [FRAC_W-1:0]  frac_w;

  stamp_scale_reg #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) scale_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (scale_we_i),
    .wdata_i (scale_wdata_i),
    .scale_o (scale_q)
  );

  stamp_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) accum_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .scale_en_i (scale_en_i),
    .scale_i    (scale_q),
    .lo_we_i    (lo_we_i),
    .hi_we_i    (hi_we_i),
    .wdata_i    (wdata_i),
    .count_o    (count_o),
    .frac_o     (frac_w)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (count_o == '0 && frac_w == '0 &&
                      scale_q == (SCALE_W'(1) << FRAC_W)));
endmodule

// File: tb/stamp_counter_tb_top.sv
`timescale 1ns/1ps
module stamp_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, scale_en_i = 1'b0, scale_we_i = 1'b0;
  logic [31:0] scale_wdata_i = '0;
  logic        lo_we_i = 1'b0, hi_we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [63:0] count_o;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  stamp_counter dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .scale_en_i(scale_en_i),
    .scale_we_i(scale_we_i), .scale_wdata_i(scale_wdata_i),
    .lo_we_i(lo_we_i), .hi_we_i(hi_we_i), .wdata_i(wdata_i),
    .count_o(count_o)
  );

  // reference: integer part and fraction held separately, carry by division
  bit [63:0] m_int;
  bit [23:0] m_frac;
  bit [31:0] m_scale;
  always @(posedge clk) begin
    longint unsigned s;
    if (!rst_n) begin
      m_int = 0; m_frac = 0; m_scale = 32'd16777216;
    end else begin
      if (lo_we_i || hi_we_i) begin
        if (lo_we_i) m_int[31:0]  = wdata_i;
        if (hi_we_i) m_int[63:32] = wdata_i;
        m_frac = 0;
      end else if (en_i) begin
        s = longint'(m_frac) + (scale_en_i ? longint'(m_scale) : 64'd16777216);
        m_int  = m_int + (s / 64'd16777216);
        m_frac = 24'(s % 64'd16777216);
      end
      if (scale_we_i) m_scale = scale_wdata_i;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the rising edge
  always @(negedge clk) if (rst_n && !done) check(cur_req, count_o, m_int);

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #400000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", count_o, 64'd0);
    step(1);

    cur_req = "R2";                    // disabled: holds at zero
    step(6);
    @(negedge clk); check("R2", count_o, 64'd0);
    step(1);

    cur_req = "R3";                    // unit stepping
    en_i = 1'b1;
    step(5);
    en_i = 1'b0;
    @(negedge clk); check("R3", count_o, 64'd5);
    step(4);
    @(negedge clk); check("R2", count_o, 64'd5);
    step(1);

    cur_req = "R1";                    // unity scale after reset
    en_i = 1'b1; scale_en_i = 1'b1;
    step(3);
    en_i = 1'b0;
    @(negedge clk); check("R1", count_o, 64'd8);
    step(1);

    cur_req = "R5";                    // scale write coinciding with ticks
    en_i = 1'b1; scale_we_i = 1'b1; scale_wdata_i = 32'h0080_0000;
    step(1);
    scale_we_i = 1'b0;
    step(4);
    en_i = 1'b0;
    @(negedge clk); check("R5", count_o, 64'd11);
    step(1);

    cur_req = "R4";                    // half-unit: fraction is now 0
    en_i = 1'b1;
    step(3);                           // 1.5 units -> frac 0.5
    en_i = 1'b0;
    @(negedge clk); check("R4", count_o, 64'd12);
    step(1);

    cur_req = "R6";                    // low load clears fraction
    lo_we_i = 1'b1; wdata_i = 32'hDEAD_BEEF;
    step(1);
    lo_we_i = 1'b0; en_i = 1'b1;
    step(1);
    en_i = 1'b0;
    @(negedge clk); check("R6", count_o, 64'h0000_0000_DEAD_BEEF);
    step(1);

    cur_req = "R7";
    hi_we_i = 1'b1; wdata_i = 32'h1234_5678;
    step(1);
    hi_we_i = 1'b0;
    @(negedge clk); check("R7", count_o, 64'h1234_5678_DEAD_BEEF);
    step(1);

    cur_req = "R9";                    // load while ticking
    scale_en_i = 1'b0; en_i = 1'b1; lo_we_i = 1'b1; wdata_i = 32'h0000_0100;
    step(1);
    lo_we_i = 1'b0; en_i = 1'b0;
    @(negedge clk); check("R9", count_o, 64'h1234_5678_0000_0100);
    step(1);

    cur_req = "R4";                    // large scale (~256 per tick)
    scale_we_i = 1'b1; scale_wdata_i = 32'hFFFF_FFFF;
    step(1);
    scale_we_i = 1'b0; scale_en_i = 1'b1; en_i = 1'b1;
    step(40);
    en_i = 1'b0;
    step(1);

    cur_req = "R8";
    lo_we_i = 1'b1; hi_we_i = 1'b1; wdata_i = 32'hFFFF_FFFF;
    step(1);
    lo_we_i = 1'b0; hi_we_i = 1'b0;
    @(negedge clk); check("R8", count_o, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1);

    cur_req = "R10";                   // wrap modulo 2^88
    scale_en_i = 1'b0; en_i = 1'b1;
    step(1);
    en_i = 1'b0;
    @(negedge clk); check("R10", count_o, 64'd0);
    step(1);

    cur_req = "R4";                    // mixed pattern of enables and scales
    scale_we_i = 1'b1; scale_wdata_i = 32'h0155_5555;
    step(1);
    scale_we_i = 1'b0;
    for (int i = 0; i < 60; i++) begin
      en_i = (i % 7) != 3;
      scale_en_i = (i % 11) < 8;
      step(1);
    end
    en_i = 1'b0;
    step(2);
    finish_run();
  end
endmodule